// File: doc/BRIEF.md
# Machine Cycle and Retire Counters

This block keeps two 64-bit machine-mode performance counters for a processor core. One counts clock cycles and the other counts retired instructions. Software sees each counter as two 32-bit CSR halves. A fifth register holds per-counter inhibit bits. All five are reached through a plain CSR port: an access strobe, a write enable, a 12-bit address, write data, combinational read data and an illegal-access flag.

The increment rules follow from one principle: a CSR write takes effect after the writing instruction has finished. So a write to a counter half replaces that half's value outright, and the same cycle's increment is lost for that half only. Whether the high half receives a carry depends on the low half's value before the cycle's write, never on the value being written. A read returns the registers' present outputs in the access cycle. The counters stop while the core is in debug mode or while the matching inhibit bit is set.

The retire strobe, the debug flag and the CSR port are control signals sampled every cycle. They have no handshake, and the block never applies back-pressure: every access completes in the cycle it is presented.

Top module: `machine_counters`

## Requirements
- R1: While reset is asserted, both halves of both counters and both inhibit bits read as zero.
- R2: A read returns the value held at the start of the access cycle. The cycle counter's low half is at 0xB00 and its high half at 0xB80. The retire counter's low half is at 0xB02 and its high half at 0xB82. The inhibit register is at 0x320.
- R3: The retire counter's low half rises by exactly one in each cycle where `retire` is high, and holds when `retire` is low.
- R4: A write of n to a counter's low half makes that half read n on the next cycle, even if the writing cycle also counted.
- R5: A counter's high half increments in every counting cycle in which its low half held all ones at the start of the cycle. This holds even when the low half is being written in that cycle.
- R6: A write to a high half replaces it completely, so a carry that arrives in the same cycle is dropped.
- R7: Inhibit bit 0 stops the cycle counter and inhibit bit 2 stops the retire counter. Only these two bits are stored, and every other inhibit bit reads zero. A change to an inhibit bit applies from the cycle after the write.
- R8: While `debug_mode` is high, neither counter advances.
- R9: The cycle counter's low half advances by one every clock cycle when it is not written, not inhibited and not in debug mode.
- R10: An access with `csr_valid` high to any other address returns zero read data, raises `csr_illegal` and changes no register. `csr_illegal` stays low when `csr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_valid | input | 1 | CSR access in this cycle |
| csr_wen | input | 1 | The access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | HALF_W | Write data |
| csr_rdata | output | HALF_W | Read data for the addressed register |
| csr_illegal | output | 1 | Access to an address that is not implemented |
| retire | input | 1 | One instruction retires this cycle |
| debug_mode | input | 1 | Core is halted in debug mode |

## Verification
A wrong internal value shows at the read port on the very next access to the affected half, because reads are combinational from the registers. The bench therefore arranges every sequence so that the write, the increment and the carry it tests are read back within one to three cycles. A carry taken from the new low value instead of the old one shows up as a high half that is off by one on the following read. A missing write priority shows up as a low half that reads n+1 instead of n. A bad inhibit or debug gate shows up as a second read that differs from the first.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  localparam int CSR_AW = 12;

  localparam logic [CSR_AW-1:0] ADDR_CY_LO = 12'hB00;
  localparam logic [CSR_AW-1:0] ADDR_CY_HI = 12'hB80;
  localparam logic [CSR_AW-1:0] ADDR_IR_LO = 12'hB02;
  localparam logic [CSR_AW-1:0] ADDR_IR_HI = 12'hB82;
  localparam logic [CSR_AW-1:0] ADDR_INH   = 12'h320;

  localparam int INH_CY_BIT = 0;
  localparam int INH_IR_BIT = 2;

  localparam int NUM_CTR = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CY_LO,
    SEL_CY_HI,
    SEL_IR_LO,
    SEL_IR_HI,
    SEL_INH
  } csr_sel_e;
endpackage

// File: rtl/ctr_decode.sv
module ctr_decode
  import ctr_pkg::*;
(
  input  logic [CSR_AW-1:0] addr,
  output csr_sel_e          sel
);
  always_comb begin
    unique case (addr)
      ADDR_CY_LO: sel = SEL_CY_LO;
      ADDR_CY_HI: sel = SEL_CY_HI;
      ADDR_IR_LO: sel = SEL_IR_LO;
      ADDR_IR_HI: sel = SEL_IR_HI;
      ADDR_INH:   sel = SEL_INH;
      default:    sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/ctr_pair.sv
module ctr_pair #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic lo_full;

  // Carry decision uses the low half as it stands before this cycle's write.
  assign lo_full = &lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      if (wr_lo)
        lo <= wdata;
      else if (step)
        lo <= lo + 1'b1;

      if (wr_hi)
        hi <= wdata;
      else if (step && lo_full)
        hi <= hi + 1'b1;
    end
  end
endmodule

// File: rtl/machine_counters.sv
module machine_counters
  import ctr_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_valid,
  input  logic              csr_wen,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [HALF_W-1:0] csr_wdata,
  output logic [HALF_W-1:0] csr_rdata,
  output logic              csr_illegal,
  input  logic              retire,
  input  logic              debug_mode
);
  localparam int MIN_W = INH_IR_BIT + 1;

  csr_sel_e          sel;
  logic              wr;
  logic              cy_inh;
  logic              ir_inh;
  logic [NUM_CTR-1:0] step;
  logic [HALF_W-1:0] lo_q [NUM_CTR];
  logic [HALF_W-1:0] hi_q [NUM_CTR];
  logic [HALF_W-1:0] cy_lo, cy_hi, ir_lo, ir_hi;

  if (HALF_W < MIN_W) begin : g_bad_width
    initial $error("HALF_W too small for inhibit bits");
  end

  ctr_decode u_decode (
    .addr (csr_addr),
    .sel  (sel)
  );

  assign wr = csr_valid && csr_wen;

  // Index 0 is the cycle counter, index 1 the retire counter.
  assign step[0] = !debug_mode && !cy_inh;
  assign step[1] = retire && !debug_mode && !ir_inh;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    localparam csr_sel_e SEL_LO = (g == 0) ? SEL_CY_LO : SEL_IR_LO;
    localparam csr_sel_e SEL_HI = (g == 0) ? SEL_CY_HI : SEL_IR_HI;

    ctr_pair #(.W(HALF_W)) u_pair (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step[g]),
      .wr_lo (wr && (sel == SEL_LO)),
      .wr_hi (wr && (sel == SEL_HI)),
      .wdata (csr_wdata),
      .lo    (lo_q[g]),
      .hi    (hi_q[g])
    );
  end

  assign cy_lo = lo_q[0];
  assign cy_hi = hi_q[0];
  assign ir_lo = lo_q[1];
  assign ir_hi = hi_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy_inh <= 1'b0;
      ir_inh <= 1'b0;
    end else if (wr && (sel == SEL_INH)) begin
      cy_inh <= csr_wdata[INH_CY_BIT];
      ir_inh <= csr_wdata[INH_IR_BIT];
    end
  end

  always_comb begin
    csr_rdata = '0;
    unique case (sel)
      SEL_CY_LO: csr_rdata = cy_lo;
      SEL_CY_HI: csr_rdata = cy_hi;
      SEL_IR_LO: csr_rdata = ir_lo;
      SEL_IR_HI: csr_rdata = ir_hi;
      SEL_INH: begin
        csr_rdata[INH_CY_BIT] = cy_inh;
        csr_rdata[INH_IR_BIT] = ir_inh;
      end
      default: csr_rdata = '0;
    endcase
  end

  assign csr_illegal = csr_valid && (sel == SEL_NONE);
endmodule

// File: rtl/ctr_checker.sv
module ctr_checker
  import ctr_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_valid,
  input logic              csr_wen,
  input logic [CSR_AW-1:0] csr_addr,
  input logic [W-1:0]      csr_wdata,
  input logic [W-1:0]      csr_rdata,
  input logic              csr_illegal,
  input logic              retire,
  input logic              debug_mode,
  input logic [W-1:0]      cy_lo,
  input logic [W-1:0]      cy_hi,
  input logic [W-1:0]      ir_lo,
  input logic [W-1:0]      ir_hi,
  input logic              cy_inh,
  input logic              ir_inh
);
  logic wr_irl, wr_irh, wr_cyl, wr_cyh, ir_run, cy_run;

  assign wr_irl = csr_valid && csr_wen && (csr_addr == ADDR_IR_LO);
  assign wr_irh = csr_valid && csr_wen && (csr_addr == ADDR_IR_HI);
  assign wr_cyl = csr_valid && csr_wen && (csr_addr == ADDR_CY_LO);
  assign wr_cyh = csr_valid && csr_wen && (csr_addr == ADDR_CY_HI);
  assign ir_run = retire && !debug_mode && !ir_inh;
  assign cy_run = !debug_mode && !cy_inh;

  AST_ILL_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> csr_rdata == '0); // R10
  AST_ILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_valid |-> !csr_illegal); // R10
  AST_RD_IR_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && !csr_wen && csr_addr == ADDR_IR_LO) |-> csr_rdata == ir_lo); // R2
  AST_IR_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_irl |=> ir_lo == $past(csr_wdata)); // R4
  AST_IR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_irl && ir_run) |=> ir_lo == W'($past(ir_lo) + 1'b1)); // R3
  AST_IR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_irl && (debug_mode || ir_inh)) |=> $stable(ir_lo)); // R8
  AST_IR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_irh && ir_run && (&ir_lo)) |=> ir_hi == W'($past(ir_hi) + 1'b1)); // R5
  AST_IR_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_irh |=> ir_hi == $past(csr_wdata)); // R6
  AST_CY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cyl && cy_run) |=> cy_lo == W'($past(cy_lo) + 1'b1)); // R9
  AST_CY_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cyh && !(&cy_lo)) |=> $stable(cy_hi)); // R5
endmodule

bind machine_counters ctr_checker #(.W(HALF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csr_valid   (csr_valid),
  .csr_wen     (csr_wen),
  .csr_addr    (csr_addr),
  .csr_wdata   (csr_wdata),
  .csr_rdata   (csr_rdata),
  .csr_illegal (csr_illegal),
  .retire      (retire),
  .debug_mode  (debug_mode),
  .cy_lo       (cy_lo),
  .cy_hi       (cy_hi),
  .ir_lo       (ir_lo),
  .ir_hi       (ir_hi),
  .cy_inh      (cy_inh),
  .ir_inh      (ir_inh)
);

// File: tb/machine_counters_test.sv
`timescale 1ns/1ps
module machine_counters_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_valid = 1'b0;
  logic        csr_wen = 1'b0;
  logic [11:0] csr_addr = 12'h0;
  logic [31:0] csr_wdata = 32'h0;
  logic [31:0] csr_rdata;
  logic        csr_illegal;
  logic        retire = 1'b0;
  logic        debug_mode = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;  // 250 MHz

  machine_counters uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_valid   (csr_valid),
    .csr_wen     (csr_wen),
    .csr_addr    (csr_addr),
    .csr_wdata   (csr_wdata),
    .csr_rdata   (csr_rdata),
    .csr_illegal (csr_illegal),
    .retire      (retire),
    .debug_mode  (debug_mode)
  );

  typedef struct packed {
    logic [11:0] a;
    logic        w;
    logic [31:0] d;
    logic        ret;
    logic        dbg;
    logic [31:0] e;
    logic        ill;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 65;
  localparam vec_t TBL [NV] = '{
    // R4 then R3: clear, read 0, read 1
    '{12'hB02, 1'b1, 32'h0,        1'b1, 1'b0, 32'h0,        1'b0, 4'd4},
    '{12'hB02, 1'b0, 32'h0,        1'b1, 1'b0, 32'h0,        1'b0, 4'd4},
    '{12'hB02, 1'b0, 32'h0,        1'b1, 1'b0, 32'h1,        1'b0, 4'd3},
    // R3: no retire, no advance
    '{12'hB02, 1'b1, 32'h5,        1'b0, 1'b0, 32'h0,        1'b0, 4'd4},
    '{12'hB02, 1'b0, 32'h0,        1'b0, 1'b0, 32'h5,        1'b0, 4'd3},
    '{12'hB02, 1'b0, 32'h0,        1'b1, 1'b0, 32'h5,        1'b0, 4'd3},
    '{12'hB02, 1'b0, 32'h0,        1'b1, 1'b0, 32'h6,        1'b0, 4'd3},
    // R5: repeated all-ones writes carry from old low
    '{12'hB02, 1'b1, 32'h0,        1'b1, 1'b0, 32'h0,        1'b0, 4'd5},
    '{12'hB82, 1'b1, 32'h0,        1'b1, 1'b0, 32'h0,        1'b0, 4'd5},
    '{12'hB02, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h0,        1'b0, 4'd5},
    '{12'hB02, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h0,        1'b0, 4'd5},
    '{12'hB02, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h0,        1'b0, 4'd5},
    '{12'hB02, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h0,        1'b0, 4'd5},
    '{12'hB02, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h0,        1'b0, 4'd5},
    '{12'hB82, 1'b0, 32'h0,        1'b1, 1'b0, 32'h4,        1'b0, 4'd5},
    '{12'hB82, 1'b0, 32'h0,        1'b1, 1'b0, 32'h5,        1'b0, 4'd5},
    '{12'hB02, 1'b0, 32'h0,        1'b1, 1'b0, 32'h1,        1'b0, 4'd5},
    // R5: full 64-bit wrap
    '{12'hB02, 1'b1, 32'h0,        1'b1, 1'b0, 32'h0,        1'b0, 4'd5},
    '{12'hB82, 1'b1, 32'h0,        1'b1, 1'b0, 32'h0,        1'b0, 4'd5},
    '{12'hB02, 1'b1, 32'hFFFFFFFE, 1'b1, 1'b0, 32'h0,        1'b0, 4'd5},
    '{12'hB82, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h0,        1'b0, 4'd5},
    '{12'hB82, 1'b0, 32'h0,        1'b1, 1'b0, 32'hFFFFFFFF, 1'b0, 4'd5},
    '{12'hB82, 1'b0, 32'h0,        1'b1, 1'b0, 32'h0,        1'b0, 4'd5},
    '{12'hB02, 1'b0, 32'h0,        1'b1, 1'b0, 32'h1,        1'b0, 4'd5},
    // R6: high write drops same-cycle carry
    '{12'hB02, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h0,        1'b0, 4'd6},
    '{12'hB82, 1'b1, 32'h7,        1'b1, 1'b0, 32'h0,        1'b0, 4'd6},
    '{12'hB82, 1'b0, 32'h0,        1'b1, 1'b0, 32'h7,        1'b0, 4'd6},
    '{12'hB02, 1'b0, 32'h0,        1'b1, 1'b0, 32'h1,        1'b0, 4'd6},
    // R7: retire inhibit (bit 2)
    '{12'h320, 1'b1, 32'h4,        1'b1, 1'b0, 32'h0,        1'b0, 4'd7},
    '{12'hB02, 1'b1, 32'h0,        1'b1, 1'b0, 32'h0,        1'b0, 4'd7},
    '{12'hB02, 1'b0, 32'h0,        1'b1, 1'b0, 32'h0,        1'b0, 4'd7},
    '{12'hB02, 1'b0, 32'h0,        1'b1, 1'b0, 32'h0,        1'b0, 4'd7},
    '{12'h320, 1'b0, 32'h0,        1'b1, 1'b0, 32'h4,        1'b0, 4'd2},
    '{12'h320, 1'b1, 32'h0,        1'b1, 1'b0, 32'h0,        1'b0, 4'd7},
    '{12'hB02, 1'b1, 32'h0,        1'b1, 1'b0, 32'h0,        1'b0, 4'd7},
    '{12'hB02, 1'b0, 32'h0,        1'b1, 1'b0, 32'h0,        1'b0, 4'd7},
    '{12'hB02, 1'b0, 32'h0,        1'b1, 1'b0, 32'h1,        1'b0, 4'd7},
    '{12'h320, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h0,        1'b0, 4'd7},
    '{12'h320, 1'b0, 32'h0,        1'b1, 1'b0, 32'h5,        1'b0, 4'd7},
    '{12'h320, 1'b1, 32'h0,        1'b1, 1'b0, 32'h0,        1'b0, 4'd7},
    // R8: debug freezes retire counter
    '{12'hB02, 1'b1, 32'h0,        1'b1, 1'b0, 32'h0,        1'b0, 4'd8},
    '{12'hB02, 1'b0, 32'h0,        1'b1, 1'b1, 32'h0,        1'b0, 4'd8},
    '{12'hB02, 1'b0, 32'h0,        1'b1, 1'b1, 32'h0,        1'b0, 4'd8},
    '{12'hB02, 1'b0, 32'h0,        1'b1, 1'b0, 32'h0,        1'b0, 4'd8},
    '{12'hB02, 1'b0, 32'h0,        1'b1, 1'b0, 32'h1,        1'b0, 4'd8},
    // R9: cycle counter runs without retire
    '{12'hB00, 1'b1, 32'hA,        1'b0, 1'b0, 32'h0,        1'b0, 4'd9},
    '{12'hB00, 1'b0, 32'h0,        1'b0, 1'b0, 32'hA,        1'b0, 4'd9},
    '{12'hB00, 1'b0, 32'h0,        1'b0, 1'b0, 32'hB,        1'b0, 4'd9},
    '{12'hB80, 1'b1, 32'h8,        1'b0, 1'b0, 32'h0,        1'b0, 4'd9},
    '{12'hB00, 1'b1, 32'hFFFFFFFF, 1'b0, 1'b0, 32'h0,        1'b0, 4'd9},
    '{12'hB80, 1'b0, 32'h0,        1'b0, 1'b0, 32'h8,        1'b0, 4'd9},
    '{12'hB80, 1'b0, 32'h0,        1'b0, 1'b0, 32'h9,        1'b0, 4'd5},
    '{12'hB00, 1'b0, 32'h0,        1'b0, 1'b0, 32'h1,        1'b0, 4'd9},
    // R7: cycle inhibit (bit 0)
    '{12'h320, 1'b1, 32'h1,        1'b0, 1'b0, 32'h0,        1'b0, 4'd7},
    '{12'hB00, 1'b1, 32'h0,        1'b0, 1'b0, 32'h0,        1'b0, 4'd7},
    '{12'hB00, 1'b0, 32'h0,        1'b0, 1'b0, 32'h0,        1'b0, 4'd7},
    '{12'hB00, 1'b0, 32'h0,        1'b0, 1'b0, 32'h0,        1'b0, 4'd7},
    '{12'h320, 1'b1, 32'h0,        1'b0, 1'b0, 32'h0,        1'b0, 4'd7},
    // R8: debug freezes cycle counter
    '{12'hB00, 1'b1, 32'h0,        1'b0, 1'b0, 32'h0,        1'b0, 4'd8},
    '{12'hB00, 1'b0, 32'h0,        1'b0, 1'b1, 32'h0,        1'b0, 4'd8},
    '{12'hB00, 1'b0, 32'h0,        1'b0, 1'b0, 32'h0,        1'b0, 4'd8},
    '{12'hB00, 1'b0, 32'h0,        1'b0, 1'b0, 32'h1,        1'b0, 4'd8},
    // R10: unmapped read and write, then prove nothing moved
    '{12'h123, 1'b0, 32'h0,        1'b0, 1'b0, 32'h0,        1'b1, 4'd10},
    '{12'hB03, 1'b1, 32'h1,        1'b0, 1'b0, 32'h0,        1'b1, 4'd10},
    '{12'hB82, 1'b0, 32'h0,        1'b0, 1'b0, 32'h7,        1'b0, 4'd10}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, sample 1 ns later, well before the next rise.
  task automatic access(input logic v, input logic [11:0] a, input logic w,
                        input logic [31:0] d, input logic ret, input logic dbg);
    @(negedge clk);
    csr_valid = v; csr_addr = a; csr_wen = w; csr_wdata = d;
    retire = ret; debug_mode = dbg;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: all registers read zero during reset
    repeat (2) @(posedge clk);
    access(1'b1, 12'hB00, 1'b0, 32'h0, 1'b0, 1'b0); check("R1 cy_lo", csr_rdata, 32'h0);
    access(1'b1, 12'hB02, 1'b0, 32'h0, 1'b0, 1'b0); check("R1 ir_lo", csr_rdata, 32'h0);
    access(1'b1, 12'hB82, 1'b0, 32'h0, 1'b0, 1'b0); check("R1 ir_hi", csr_rdata, 32'h0);
    access(1'b1, 12'h320, 1'b0, 32'h0, 1'b0, 1'b0); check("R1 inhibit", csr_rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = TBL[i];
      access(1'b1, v.a, v.w, v.d, v.ret, v.dbg);
      tag = $sformatf("R%0d vec%0d", v.r, i);
      if (!v.w) check({tag, " rdata"}, csr_rdata, v.e);
      check({tag, " illegal"}, {31'b0, csr_illegal}, {31'b0, v.ill});
    end

    // R10: no flag without an access
    access(1'b0, 12'h123, 1'b0, 32'h0, 1'b0, 1'b0);
    check("R10 idle illegal", {31'b0, csr_illegal}, 32'h0);

    // R1: reset mid-run clears a nonzero high half
    @(negedge clk);
    rst_n = 1'b0;
    access(1'b1, 12'hB82, 1'b0, 32'h0, 1'b0, 1'b0);
    check("R1 reset ir_hi", csr_rdata, 32'h0);
    access(1'b1, 12'hB80, 1'b0, 32'h0, 1'b0, 1'b0);
    check("R1 reset cy_hi", csr_rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    csr_valid = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule